// File: doc/BRIEF.md
# Timer Capture/Compare Channel Unit

A set of identical capture/compare channels that sit around a shared free-running timer counter. Each channel keeps its value in two registers. The bus-side preload register is the only one software can read or write. The shadow register is internal. In compare mode, the preload value flows into the shadow, either at once on a bus write or on the next timer update event. The counter is then compared with the shadow, and a one-cycle match pulse is produced. In capture mode, the flow runs the other way. A qualified input edge, divided down by a per-channel prescaler, latches the counter into the shadow and into the preload in the same step.

Every capture or match sets the channel's event flag. A capture that arrives while that flag is still set also raises an over-capture flag, which shows that software missed a value. Flags are cleared by writing ones. Software can also force an event on any channel with a generate write.

Top module: `tmr_ccu`

## Requirements
- R1: After reset, every configuration word, preload value, shadow value and flag reads zero, and `match_o` is low.
- R2: A bus write to value address `NUM_CH+i` loads the preload register of channel i only, and a read of that address returns the preload register.
- R3: Channel configuration sits at address i. Bit 0 selects capture mode when it is 1, bit 1 is the enable, bit 2 is the preload enable and bits 4:3 hold the prescaler code. In compare mode with preload disabled, a value write also loads the shadow at the same clock edge.
- R4: In compare mode with preload enabled, the shadow changes only on a cycle with `upd_evt_i` high, and it then takes the preload value present before that edge.
- R5: In compare mode with the enable set, `match_o[i]` is high in every cycle where `cnt_i` equals the shadow, and the event flag is set at the following edge. With the enable clear, no match occurs.
- R6: In capture mode, a capture event loads `cnt_i` into both the shadow and the preload, and it sets the event flag at that edge.
- R7: The capture prescaler takes a capture on every 1st, 2nd, 4th or 8th qualified edge for codes 0, 1, 2 and 3. Writing the configuration word restarts the edge count.
- R8: A capture that occurs while the channel's event flag is already set also sets its over-capture flag.
- R9: The status word at address `2*NUM_CH` holds the event flags in bits `NUM_CH-1:0` and the over-capture flags in bits `2*NUM_CH-1:NUM_CH`. Writing a 1 to a bit clears that flag. If a set and a clear fall in the same cycle, the flag ends up set.
- R10: Writing a 1 to bit i at address `2*NUM_CH+1` forces an event on channel i in that cycle, whatever the enable and prescaler settings. In capture mode this is a capture. In compare mode it raises `match_o[i]` in that same cycle. This address reads as zero.
- R11: When a capture and a bus value write fall in the same cycle, the captured counter value is kept.
- R12: Input edges on a capture channel whose enable is clear change neither its value nor its flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_i | input | CNT_W | Shared timer counter value |
| upd_evt_i | input | 1 | Timer update event, one cycle |
| edge_i | input | NUM_CH | Qualified input edge pulse per channel |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | CNT_W | Register write data |
| reg_rdata_o | output | CNT_W | Register read data (combinational) |
| match_o | output | NUM_CH | Compare match pulse per channel |
| ccif_o | output | NUM_CH | Event flag per channel |
| ocf_o | output | NUM_CH | Over-capture flag per channel |

## Verification
Several properties are checked on every cycle. A capture must latch the counter into both registers and set the flag. A match must be followed by the flag. A match without a generate write needs an enabled compare channel. The shadow must hold still under preload until an update arrives, and over-capture may rise only over a flag that is already set. Some behaviour only the bench scenarios can show. These are the prescaler counting to 4 across several edges, the order of preload and update, the set-over-clear priority, the capture winning over a bus write, and disabled channels ignoring edges. All of these are checked through reads of the value and status words.

// File: rtl/tmr_ccu_pkg.sv
package tmr_ccu_pkg;

  typedef enum logic {
    CC_CMP = 1'b0,
    CC_CAP = 1'b1
  } cc_mode_e;

  // packed LSB first in the register word: mode[0], en[1], pre_en[2], psc[4:3]
  typedef struct packed {
    logic [1:0] psc;
    logic       pre_en;
    logic       en;
    cc_mode_e   mode;
  } ch_cfg_t;

  localparam int CFG_W = $bits(ch_cfg_t);

endpackage

// File: rtl/tmr_ccu_psc.sv
module tmr_ccu_psc #(
  parameter int DIV_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             edge_i,
  output logic             evt_o
);

  localparam int PW = (1 << DIV_W) - 1;

  logic [PW-1:0] cnt_q;
  logic [PW:0]   lim_w;

  // edges per event minus one: 2**div - 1
  assign lim_w = ((PW + 1)'(1) << div_i) - (PW + 1)'(1);
  assign evt_o = en_i && edge_i && (cnt_q == lim_w[PW-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (clr_i || !en_i) cnt_q <= '0;
    else if (evt_o)       cnt_q <= '0;
    else if (edge_i)      cnt_q <= cnt_q + PW'(1);
  end

endmodule

// File: rtl/tmr_ccu_chan.sv
module tmr_ccu_chan
  import tmr_ccu_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ch_cfg_t          cfg_i,
  input  logic             cfg_wr_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             edge_i,
  input  logic             upd_i,
  input  logic             ccr_wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             sw_gen_i,
  input  logic             clr_ccif_i,
  input  logic             clr_ocf_i,
  output logic [CNT_W-1:0] ccr_o,
  output logic [CNT_W-1:0] shadow_o,
  output logic             cap_evt_o,
  output logic             match_o,
  output logic             ccif_o,
  output logic             ocf_o
);

  logic             cap_mode;
  logic             edge_evt;
  logic             cmp_hit;
  logic [CNT_W-1:0] pre_q, sh_q;
  logic             ccif_q, ocf_q;

  assign cap_mode = (cfg_i.mode == CC_CAP);

  tmr_ccu_psc #(.DIV_W(2)) u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (cap_mode && cfg_i.en),
    .clr_i  (cfg_wr_i),
    .div_i  (cfg_i.psc),
    .edge_i (edge_i),
    .evt_o  (edge_evt)
  );

  assign cap_evt_o = cap_mode && (edge_evt || sw_gen_i);
  assign cmp_hit   = !cap_mode && cfg_i.en && (cnt_i == sh_q);
  assign match_o   = cmp_hit || (!cap_mode && sw_gen_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      sh_q  <= '0;
    end else if (cap_evt_o) begin
      pre_q <= cnt_i;
      sh_q  <= cnt_i;
    end else begin
      if (ccr_wr_i) pre_q <= wdata_i;
      if (!cap_mode) begin
        if (ccr_wr_i && !cfg_i.pre_en)   sh_q <= wdata_i;
        else if (upd_i && cfg_i.pre_en)  sh_q <= pre_q;
      end
    end
  end

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ccif_q <= 1'b0;
      ocf_q  <= 1'b0;
    end else begin
      ccif_q <= (cap_evt_o || match_o) || (ccif_q && !clr_ccif_i);
      ocf_q  <= (cap_evt_o && ccif_q) || (ocf_q && !clr_ocf_i);
    end
  end

  assign ccr_o    = pre_q;
  assign shadow_o = sh_q;
  assign ccif_o   = ccif_q;
  assign ocf_o    = ocf_q;

endmodule

// File: rtl/tmr_ccu.sv
module tmr_ccu
  import tmr_ccu_pkg::*;
#(
  parameter int  NUM_CH = 4,
  parameter int  CNT_W  = 16,
  localparam int ADDR_W = $clog2(2 * NUM_CH + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              upd_evt_i,
  input  logic [NUM_CH-1:0] edge_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [CNT_W-1:0]  reg_wdata_i,
  output logic [CNT_W-1:0]  reg_rdata_o,
  output logic [NUM_CH-1:0] match_o,
  output logic [NUM_CH-1:0] ccif_o,
  output logic [NUM_CH-1:0] ocf_o
);

  localparam int A_VAL  = NUM_CH;
  localparam int A_STAT = 2 * NUM_CH;
  localparam int A_GEN  = 2 * NUM_CH + 1;

  ch_cfg_t          cfg_q    [NUM_CH];
  logic [CNT_W-1:0] ccr_q    [NUM_CH];
  logic [CNT_W-1:0] shadow_q [NUM_CH];
  logic [NUM_CH-1:0] cap_evt;
  logic              stat_wr, gen_wr;

  assign stat_wr = reg_wr_i && (reg_addr_i == ADDR_W'(A_STAT));
  assign gen_wr  = reg_wr_i && (reg_addr_i == ADDR_W'(A_GEN));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic cfg_wr, ccr_wr;

    assign cfg_wr = reg_wr_i && (reg_addr_i == ADDR_W'(i));
    assign ccr_wr = reg_wr_i && (reg_addr_i == ADDR_W'(A_VAL + i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cfg_q[i] <= '0;
      else if (cfg_wr) cfg_q[i] <= ch_cfg_t'(reg_wdata_i[CFG_W-1:0]);
    end

    tmr_ccu_chan #(.CNT_W(CNT_W)) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cfg_i      (cfg_q[i]),
      .cfg_wr_i   (cfg_wr),
      .cnt_i      (cnt_i),
      .edge_i     (edge_i[i]),
      .upd_i      (upd_evt_i),
      .ccr_wr_i   (ccr_wr),
      .wdata_i    (reg_wdata_i),
      .sw_gen_i   (gen_wr && reg_wdata_i[i]),
      .clr_ccif_i (stat_wr && reg_wdata_i[i]),
      .clr_ocf_i  (stat_wr && reg_wdata_i[NUM_CH+i]),
      .ccr_o      (ccr_q[i]),
      .shadow_o   (shadow_q[i]),
      .cap_evt_o  (cap_evt[i]),
      .match_o    (match_o[i]),
      .ccif_o     (ccif_o[i]),
      .ocf_o      (ocf_o[i])
    );
  end

  always_comb begin
    reg_rdata_o = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (reg_addr_i == ADDR_W'(i))
        reg_rdata_o = {{(CNT_W-CFG_W){1'b0}}, cfg_q[i]};
      if (reg_addr_i == ADDR_W'(A_VAL + i))
        reg_rdata_o = ccr_q[i];
    end
    if (reg_addr_i == ADDR_W'(A_STAT))
      reg_rdata_o = {{(CNT_W-2*NUM_CH){1'b0}}, ocf_o, ccif_o};
  end

endmodule

// File: rtl/tmr_ccu_chk.sv
module tmr_ccu_chk
  import tmr_ccu_pkg::*;
#(
  parameter int  NUM_CH = 4,
  parameter int  CNT_W  = 16,
  localparam int ADDR_W = $clog2(2 * NUM_CH + 2)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CNT_W-1:0]  cnt_i,
  input logic              upd_evt_i,
  input logic              reg_wr_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [CNT_W-1:0]  reg_wdata_i,
  input logic [NUM_CH-1:0] match_o,
  input logic [NUM_CH-1:0] ccif_o,
  input logic [NUM_CH-1:0] ocf_o,
  input logic [NUM_CH-1:0] cap_evt,
  input ch_cfg_t           cfg_q    [NUM_CH],
  input logic [CNT_W-1:0]  ccr_q    [NUM_CH],
  input logic [CNT_W-1:0]  shadow_q [NUM_CH]
);

  localparam int A_STAT = 2 * NUM_CH;
  localparam int A_GEN  = 2 * NUM_CH + 1;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_a

    p_ovr_over_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ocf_o[i]) |-> $past(ccif_o[i]));

    p_cap_latch_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cap_evt[i] |=> (ccif_o[i] && ccr_q[i] == $past(cnt_i) && shadow_q[i] == $past(cnt_i)));

    p_match_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      match_o[i] |=> ccif_o[i]);

    p_match_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (match_o[i] && !(reg_wr_i && reg_addr_i == ADDR_W'(A_GEN)))
        |-> (cfg_q[i].en && cfg_q[i].mode == CC_CMP));

    p_shadow_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_q[i].mode == CC_CMP && cfg_q[i].pre_en && !upd_evt_i) |=> $stable(shadow_q[i]));

    p_direct_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_wr_i && reg_addr_i == ADDR_W'(NUM_CH + i) && cfg_q[i].mode == CC_CMP && !cfg_q[i].pre_en)
        |=> shadow_q[i] == $past(reg_wdata_i));

    p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_wr_i && reg_addr_i == ADDR_W'(A_STAT) && reg_wdata_i[i] && !cap_evt[i] && !match_o[i])
        |=> !ccif_o[i]);
  end

endmodule

bind tmr_ccu tmr_ccu_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cnt_i       (cnt_i),
  .upd_evt_i   (upd_evt_i),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .match_o     (match_o),
  .ccif_o      (ccif_o),
  .ocf_o       (ocf_o),
  .cap_evt     (cap_evt),
  .cfg_q       (cfg_q),
  .ccr_q       (ccr_q),
  .shadow_q    (shadow_q)
);

// File: tb/tmr_ccu_bench.sv
module tmr_ccu_bench;

  localparam int NUM_CH = 4;
  localparam int CNT_W  = 16;
  localparam int ADDR_W = $clog2(2 * NUM_CH + 2);
  localparam int A_VAL  = NUM_CH;
  localparam int A_STAT = 2 * NUM_CH;
  localparam int A_GEN  = 2 * NUM_CH + 1;
  localparam logic [CNT_W-1:0] IDLE = 16'h7777;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [CNT_W-1:0]  cnt = '0;
  logic              upd = 1'b0;
  logic [NUM_CH-1:0] edges = '0;
  logic              reg_wr = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [CNT_W-1:0]  reg_wdata = '0;
  logic [CNT_W-1:0]  reg_rdata;
  logic [NUM_CH-1:0] match, ccif, ocf;

  always #10 clk = ~clk;

  tmr_ccu #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_tmr_ccu (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cnt_i       (cnt),
    .upd_evt_i   (upd),
    .edge_i      (edges),
    .reg_wr_i    (reg_wr),
    .reg_addr_i  (reg_addr),
    .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata),
    .match_o     (match),
    .ccif_o      (ccif),
    .ocf_o       (ocf)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  // reference state built from the requirements
  logic [4:0]        m_cfg [NUM_CH];
  logic [CNT_W-1:0]  m_pre [NUM_CH];
  logic [CNT_W-1:0]  m_sh  [NUM_CH];
  int                m_psc [NUM_CH];
  logic [NUM_CH-1:0] m_ccif = '0;
  logic [NUM_CH-1:0] m_ocf  = '0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [NUM_CH-1:0] exp_match(logic we, logic [ADDR_W-1:0] a,
                                                  logic [CNT_W-1:0] wd, logic [CNT_W-1:0] c);
    logic [NUM_CH-1:0] r = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      logic gen = we && (a == ADDR_W'(A_GEN)) && wd[i];
      if (!m_cfg[i][0] && ((m_cfg[i][1] && c == m_sh[i]) || gen)) r[i] = 1'b1;
    end
    return r;
  endfunction

  function automatic logic [CNT_W-1:0] exp_rd(logic [ADDR_W-1:0] a);
    for (int i = 0; i < NUM_CH; i++) begin
      if (a == ADDR_W'(i))         return CNT_W'(m_cfg[i]);
      if (a == ADDR_W'(A_VAL + i)) return m_pre[i];
    end
    if (a == ADDR_W'(A_STAT)) return CNT_W'({m_ocf, m_ccif});
    return '0;
  endfunction

  task automatic model_step(logic we, logic [ADDR_W-1:0] a, logic [CNT_W-1:0] wd,
                            logic [NUM_CH-1:0] ed, logic up, logic [CNT_W-1:0] c);
    logic [NUM_CH-1:0] mt = exp_match(we, a, wd, c);
    logic [NUM_CH-1:0] nccif, nocf;
    for (int i = 0; i < NUM_CH; i++) begin
      logic cap  = m_cfg[i][0];
      logic en   = m_cfg[i][1];
      logic pen  = m_cfg[i][2];
      int   lim  = (1 << m_cfg[i][4:3]) - 1;
      logic gen  = we && (a == ADDR_W'(A_GEN)) && wd[i];
      logic cwr  = we && (a == ADDR_W'(i));
      logic vwr  = we && (a == ADDR_W'(A_VAL + i));
      logic swr  = we && (a == ADDR_W'(A_STAT));
      logic eev  = cap && en && ed[i] && (m_psc[i] == lim);
      logic cev  = cap && (eev || gen);
      logic [CNT_W-1:0] old_pre = m_pre[i];
      nccif[i] = cev || mt[i] || (m_ccif[i] && !(swr && wd[i]));
      nocf[i]  = (cev && m_ccif[i]) || (m_ocf[i] && !(swr && wd[NUM_CH+i]));
      if (cev) begin
        m_pre[i] = c;
        m_sh[i]  = c;
      end else begin
        if (vwr) m_pre[i] = wd;
        if (!cap) begin
          if (vwr && !pen)    m_sh[i] = wd;
          else if (up && pen) m_sh[i] = old_pre;
        end
      end
      if (cwr || !(cap && en)) m_psc[i] = 0;
      else if (eev)            m_psc[i] = 0;
      else if (ed[i])          m_psc[i] = m_psc[i] + 1;
      if (cwr) m_cfg[i] = wd[4:0];
    end
    m_ccif = nccif;
    m_ocf  = nocf;
  endtask

  // one clock: drive just after a falling edge, check combinational match, then flags after the edge
  task automatic cycle(string tag, logic we, logic [ADDR_W-1:0] a, logic [CNT_W-1:0] wd,
                       logic [NUM_CH-1:0] ed, logic up, logic [CNT_W-1:0] c);
    reg_wr = we; reg_addr = a; reg_wdata = wd; edges = ed; upd = up; cnt = c;
    #1;
    check({tag, " match"}, 32'(match), 32'(exp_match(we, a, wd, c)));
    model_step(we, a, wd, ed, up, c);
    @(negedge clk);
    reg_wr = 1'b0; edges = '0; upd = 1'b0;
    check({tag, " ccif"}, 32'(ccif), 32'(m_ccif));
    check({tag, " ocf"},  32'(ocf),  32'(m_ocf));
  endtask

  task automatic rd(string tag, logic [ADDR_W-1:0] a, logic [CNT_W-1:0] exp);
    reg_addr = a;
    #1;
    check(tag, 32'(reg_rdata), 32'(exp));
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    for (int i = 0; i < NUM_CH; i++) begin
      m_cfg[i] = '0; m_pre[i] = '0; m_sh[i] = '0; m_psc[i] = 0;
    end
    cnt = IDLE;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd("R1 cfg0", 0, 0);
    rd("R1 val0", ADDR_W'(A_VAL), 0);
    rd("R1 status", ADDR_W'(A_STAT), 0);
    check("R1 match", 32'(match), 0);

    // R3 compare, preload off: write goes straight to shadow
    cycle("R3 cfg",   1, 0, 16'h0002, 0, 0, IDLE);
    cycle("R3 write", 1, ADDR_W'(A_VAL), 16'd100, 0, 0, IDLE);
    rd("R2 readback", ADDR_W'(A_VAL), 16'd100);
    cycle("R5 match", 0, 0, 0, 0, 0, 16'd100);
    check("R5 flag set", 32'(ccif[0]), 1);

    // R9 write-one-clear and set priority
    cycle("R9 clear", 1, ADDR_W'(A_STAT), 16'h0001, 0, 0, IDLE);
    check("R9 cleared", 32'(ccif[0]), 0);
    cycle("R9 set wins", 1, ADDR_W'(A_STAT), 16'h0001, 0, 0, 16'd100);
    check("R9 set wins", 32'(ccif[0]), 1);

    // R5 disabled compare channel
    cycle("R5 disable", 1, 0, 16'h0000, 0, 0, IDLE);
    cycle("R9 clear",   1, ADDR_W'(A_STAT), 16'h0001, 0, 0, IDLE);
    cycle("R5 disabled", 0, 0, 0, 0, 0, 16'd100);
    check("R5 no flag when disabled", 32'(ccif[0]), 0);

    // R4 preload enabled: shadow waits for update
    cycle("R4 cfg",   1, 1, 16'h0006, 0, 0, IDLE);
    cycle("R4 write", 1, ADDR_W'(A_VAL + 1), 16'd200, 0, 0, IDLE);
    cycle("R4 no upd", 0, 0, 0, 0, 0, 16'd200);
    check("R4 no match before update", 32'(ccif[1]), 0);
    rd("R2 preload readback", ADDR_W'(A_VAL + 1), 16'd200);
    cycle("R4 upd",   0, 0, 0, 0, 1, IDLE);
    cycle("R4 match", 0, 0, 0, 0, 0, 16'd200);
    check("R4 match after update", 32'(ccif[1]), 1);

    // R7 prescaler code 2 -> every 4th edge; R6 capture
    cycle("R7 cfg", 1, 2, 16'h0013, 0, 0, IDLE);
    for (int k = 0; k < 3; k++) cycle("R7 edge", 0, 0, 0, 4'b0100, 0, CNT_W'(10 + k));
    check("R7 no capture after 3 edges", 32'(ccif[2]), 0);
    cycle("R6 4th edge", 0, 0, 0, 4'b0100, 0, 16'd13);
    check("R6 capture flag", 32'(ccif[2]), 1);
    rd("R6 captured value", ADDR_W'(A_VAL + 2), 16'd13);

    // R8 over-capture
    for (int k = 0; k < 4; k++) cycle("R8 edge", 0, 0, 0, 4'b0100, 0, CNT_W'(20 + k));
    check("R8 over-capture flag", 32'(ocf[2]), 1);
    rd("R8 newest value", ADDR_W'(A_VAL + 2), 16'd23);

    // R11 capture beats bus write
    cycle("R11 cfg", 1, 3, 16'h0003, 0, 0, IDLE);
    cycle("R11 collide", 1, ADDR_W'(A_VAL + 3), 16'd555, 4'b1000, 0, 16'd42);
    rd("R11 capture kept", ADDR_W'(A_VAL + 3), 16'd42);

    // R12 disabled capture channel ignores edges
    cycle("R12 cfg",   1, 3, 16'h0001, 0, 0, IDLE);
    cycle("R12 clear", 1, ADDR_W'(A_STAT), 16'h0008, 0, 0, IDLE);
    cycle("R12 edge",  0, 0, 0, 4'b1000, 0, 16'd99);
    rd("R12 value unchanged", ADDR_W'(A_VAL + 3), 16'd42);
    check("R12 flag unchanged", 32'(ccif[3]), 0);

    // R10 software generate
    cycle("R10 gen capture", 1, ADDR_W'(A_GEN), 16'h0004, 0, 0, 16'd777);
    rd("R10 forced capture", ADDR_W'(A_VAL + 2), 16'd777);
    rd("R10 gen reads zero", ADDR_W'(A_GEN), 0);
    cycle("R10 gen compare", 1, ADDR_W'(A_GEN), 16'h0001, 0, 0, IDLE);
    check("R10 forced compare flag", 32'(ccif[0]), 1);

    // mixed random traffic against the reference model (R2..R12)
    for (int n = 0; n < 3000; n++) begin
      logic              we  = ($urandom % 4) == 0;
      logic [ADDR_W-1:0] a   = ADDR_W'($urandom % (A_GEN + 1));
      logic [CNT_W-1:0]  wd  = CNT_W'($urandom % 32);
      logic [NUM_CH-1:0] ed  = NUM_CH'($urandom);
      logic              up  = ($urandom % 8) == 0;
      logic [CNT_W-1:0]  c   = CNT_W'($urandom % 24);
      if (n % 8 == 0) begin
        logic [ADDR_W-1:0] ra = ADDR_W'($urandom % (A_GEN + 1));
        rd("R2 random read", ra, exp_rd(ra));
      end
      cycle("R7 random", we, a, wd, ed, up, c);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule